// File: doc/BRIEF.md
# Seven-Tap Vertical Pixel Filter

This block filters one image column at a time. Packed 32-bit pixels of a column enter top to bottom over a valid/ready input. Each colour channel is widened to its own 16-bit lane and multiplied by a symmetric seven-tap kernel. Each lane sum is rounded and cut back to eight bits, and the four bytes are packed into a 32-bit output pixel. Every input pixel is used exactly once. Its contributions go into a short chain of partial-sum registers, one register per output still in progress, so no line buffer is needed.

The kernel has fixed-point weights with eight fraction bits, and all arithmetic wraps modulo 2^16 per lane. A column-start strobe empties the chain before a new column. Once the seventh pixel of a column has been accepted, one filtered pixel leaves for every further accepted pixel. Each output carries the row index it belongs to. When the consumer holds back its ready, the whole block stalls and no partial sum is lost. Windows that would reach past either end of the column produce no output.

Top module: `vcol_fir7`

## Requirements
- R1: Input and output pixels use the same packing: bits 31:24, 23:16, 15:8 and 7:0 each hold one unsigned 8-bit channel. Each channel is zero-extended to a 16-bit lane and filtered with no influence from the other three.
- R2: The output tagged with row r equals, per lane, the sum over k = 0..6 of pixel[r+k] times h_k. Here h0 = h6 = `tap_edge`, h1 = h5 = `tap_near`, h2 = h4 = `tap_mid` and h3 = `tap_center`.
- R3: Each lane sum has 0x0080 added to it, modulo 2^16. It is then shifted right logically by 8, and bits 15:8 of the biased sum become the output byte.
- R4: Each product keeps only its low 16 bits and every addition wraps modulo 2^16, with no saturation.
- R5: No output appears before the seventh accepted pixel of a column. After that, each accepted pixel yields exactly one output. `out_row` counts 0, 1, 2, ... within the column, so a column of H pixels gives H-6 outputs.
- R6: While `col_start` is high, `in_ready` is low. On the next cycle `out_valid` is low, the row count is zero and all partial sums are cleared, so earlier pixels have no effect on the new column.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_pix` and `out_row` hold their values.
- R8: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_start | input | 1 | One-cycle strobe that empties the filter before a new column |
| tap_edge | input | 16 | Weight of the outermost taps (h0, h6) |
| tap_near | input | 16 | Weight of taps h1 and h5 |
| tap_mid | input | 16 | Weight of taps h2 and h4 |
| tap_center | input | 16 | Weight of the centre tap h3 |
| in_valid | input | 1 | Input pixel is present |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_pix | input | 32 | Packed input pixel |
| out_valid | output | 1 | Output pixel is present |
| out_ready | input | 1 | Consumer takes the output pixel this cycle |
| out_pix | output | 32 | Packed filtered pixel |
| out_row | output | ROW_W | Row index of the output within its column |

## Verification
The bench aims at lane mix-ups. A centre-only kernel makes each output a shifted copy of its input, so a swapped or shifted byte lane shows up at once. A rounding step that dropped the bias or took the wrong bits fails the single-unit kernel, which must return 0 or 1 depending on the top bit of the channel. A datapath that saturated, or kept wide sums, would go wrong on the kernel with oversized weights, whose sums overflow 16 bits. The bench also checks the timing and control paths. A chain that emitted outputs too early, or kept stale partial sums after a column restart, would give extra or wrong rows. A block that lost its hold under long output stalls would change a pixel while it is held or take input it cannot store.

// File: rtl/vfir_pkg.sv
package vfir_pkg;

  localparam int TAPS   = 7;
  localparam int NSUM   = TAPS - 1;
  localparam int LANES  = 4;
  localparam int CH_W   = 8;
  localparam int LANE_W = 16;
  localparam int PIX_W  = LANES * CH_W;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [CH_W-1:0]   chan_t;

  localparam lane_t ROUND_BIAS = lane_t'(16'h0080);

  // Widen one channel byte to a lane.
  function automatic lane_t widen(chan_t c);
    return {{(LANE_W-CH_W){1'b0}}, c};
  endfunction

  // Multiply-accumulate keeping the low lane bits only.
  function automatic lane_t lane_mac(lane_t acc, lane_t x, lane_t w);
    logic [2*LANE_W-1:0] full;
    full = {{LANE_W{1'b0}}, x} * {{LANE_W{1'b0}}, w};
    return acc + full[LANE_W-1:0];
  endfunction

  // Round half up and keep the integer byte.
  function automatic chan_t lane_round(lane_t s);
    lane_t b;
    b = s + ROUND_BIAS;
    return b[LANE_W-1 -: CH_W];
  endfunction

  // Map a tap index onto the symmetric weight set.
  function automatic lane_t tap_weight(int k, lane_t w_edge, lane_t w_near,
                                       lane_t w_mid, lane_t w_ctr);
    case (k)
      0, 6:    return w_edge;
      1, 5:    return w_near;
      2, 4:    return w_mid;
      default: return w_ctr;
    endcase
  endfunction

endpackage

// File: rtl/vfir_lane.sv
module vfir_lane
  import vfir_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  adv,
  input  lane_t x,
  input  lane_t w [TAPS],
  output lane_t done_sum
);

  // psum[j] holds the partial result for the output that completes j+1 pixels later.
  lane_t psum [NSUM];

  assign done_sum = lane_mac(psum[0], x, w[TAPS-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NSUM; j++) psum[j] <= '0;
    end else if (clr) begin
      for (int j = 0; j < NSUM; j++) psum[j] <= '0;
    end else if (adv) begin
      for (int j = 0; j < NSUM-1; j++) psum[j] <= lane_mac(psum[j+1], x, w[TAPS-2-j]);
      psum[NSUM-1] <= lane_mac('0, x, w[0]);
    end
  end

endmodule

// File: rtl/vfir_ctrl.sv
module vfir_ctrl
  import vfir_pkg::*;
#(
  parameter int ROW_W = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_start,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             accept,
  output logic             load_out,
  output logic             out_valid,
  output logic [ROW_W-1:0] out_row
);

  logic [ROW_W-1:0] row_cnt;
  logic             warm;

  assign in_ready = !col_start && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;
  assign warm     = (row_cnt >= ROW_W'(NSUM));
  assign load_out = accept && warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_cnt   <= '0;
      out_valid <= 1'b0;
      out_row   <= '0;
    end else if (col_start) begin
      row_cnt   <= '0;
      out_valid <= 1'b0;
    end else begin
      if (accept && (row_cnt != '1)) row_cnt <= row_cnt + 1'b1;
      if (load_out) begin
        out_valid <= 1'b1;
        out_row   <= row_cnt - ROW_W'(NSUM);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vcol_fir7.sv
module vcol_fir7
  import vfir_pkg::*;
#(
  parameter int ROWS  = 58,
  localparam int ROW_W = $clog2(ROWS + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_start,
  input  logic [15:0]      tap_edge,
  input  logic [15:0]      tap_near,
  input  logic [15:0]      tap_mid,
  input  logic [15:0]      tap_center,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_pix,
  output logic [ROW_W-1:0] out_row
);

  logic        accept;
  logic        load_out;
  lane_t       w [TAPS];
  lane_t       lane_sum [LANES];
  chan_t       lane_byte [LANES];
  logic [31:0] next_pix;

  always_comb begin
    for (int k = 0; k < TAPS; k++)
      w[k] = tap_weight(k, tap_edge, tap_near, tap_mid, tap_center);
  end

  vfir_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .col_start (col_start),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .accept    (accept),
    .load_out  (load_out),
    .out_valid (out_valid),
    .out_row   (out_row)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vfir_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (col_start),
      .adv      (accept),
      .x        (widen(in_pix[g*CH_W +: CH_W])),
      .w        (w),
      .done_sum (lane_sum[g])
    );
    assign lane_byte[g] = lane_round(lane_sum[g]);
    assign next_pix[g*CH_W +: CH_W] = lane_byte[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_pix <= '0;
    else if (load_out) out_pix <= next_pix;
  end

endmodule

// File: rtl/vfir_chk.sv
module vfir_chk #(
  parameter int ROW_W = 6
)(
  input logic             clk,
  input logic             rst_n,
  input logic             col_start,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_pix,
  input logic [ROW_W-1:0] out_row,
  input logic             accept,
  input logic             load_out
);

  p_block_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !col_start) |=> (out_valid && $stable(out_pix) && $stable(out_row)));

  p_start_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    col_start |-> !in_ready);

  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    col_start |=> !out_valid);

  p_out_from_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(accept));

  p_load_shows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_out |=> out_valid);

endmodule

bind vcol_fir7 vfir_chk #(.ROW_W(ROW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .col_start (col_start),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix),
  .out_row   (out_row),
  .accept    (accept),
  .load_out  (load_out)
);

// File: tb/vcol_fir7_test.sv
module vcol_fir7_test;

  localparam int ROWS  = 58;
  localparam int ROW_W = $clog2(ROWS + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             col_start = 1'b0;
  logic [15:0]      tap_edge = 16'd4, tap_near = 16'd24, tap_mid = 16'd60, tap_center = 16'd80;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [31:0]      in_pix = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [31:0]      out_pix;
  logic [ROW_W-1:0] out_row;

  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;
  logic [31:0] col_px [0:63];

  always #4 clk = ~clk;

  vcol_fir7 #(.ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .col_start(col_start),
    .tap_edge(tap_edge), .tap_near(tap_near), .tap_mid(tap_mid), .tap_center(tap_center),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_row(out_row)
  );

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", wd);
      summary();
    end
  end

  function automatic int unsigned weight(int k);
    if (k == 0 || k == 6) return tap_edge;
    if (k == 1 || k == 5) return tap_near;
    if (k == 2 || k == 4) return tap_mid;
    return tap_center;
  endfunction

  // Reference: wide integer sums, reduced modulo 2^16 at the end.
  function automatic logic [31:0] ref_out(int r);
    logic [31:0] res;
    for (int ch = 0; ch < 4; ch++) begin
      int unsigned acc = 0;
      for (int k = 0; k < 7; k++)
        acc += int'(col_px[r+k][ch*8 +: 8]) * weight(k);
      acc = (acc + 128) % 65536;
      res[ch*8 +: 8] = 8'(acc / 256);
    end
    return res;
  endfunction

  task automatic fill_rand(int h);
    for (int i = 0; i < h; i++) col_px[i] = $urandom;
  endtask

  task automatic fill_const(int h, logic [31:0] v);
    for (int i = 0; i < h; i++) col_px[i] = v;
  endtask

  task automatic start_col();
    @(negedge clk);
    col_start = 1'b1;
    in_valid  = 1'b1;
    in_pix    = $urandom;
    #1;
    check(in_ready == 1'b0, "R6", "in_ready during col_start", 32'(in_ready), 32'd0);
    @(negedge clk);
    col_start = 1'b0;
    in_valid  = 1'b0;
    out_ready = 1'b1;
    #1;
    check(out_valid == 1'b0, "R6", "out_valid after col_start", 32'(out_valid), 32'd0);
  endtask

  // Push n random pixels without caring about outputs.
  task automatic feed_junk(int n, bit rdy);
    int sent = 0;
    int cyc = 0;
    while (sent < n && cyc < 50) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_pix    = $urandom;
      out_ready = rdy;
      #1;
      if (in_ready) sent++;
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_col(int h, int stall_pct, int gap_pct, string req);
    int sent = 0;
    int got = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic [31:0] prev_pix = '0;
    while ((sent < h || got < h - 6) && cyc < 6000) begin
      @(negedge clk);
      in_valid  = (sent < h) && ($urandom_range(99) >= gap_pct);
      in_pix    = in_valid ? col_px[sent] : $urandom;
      out_ready = ($urandom_range(99) >= stall_pct);
      #1;
      if (prev_stall && out_valid)
        check(out_pix == prev_pix, "R7", "held pixel changed", out_pix, prev_pix);
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R7", "in_ready while stalled", 32'(in_ready), 32'd0);
      if (out_valid && out_ready) begin
        check(sent >= 7, "R5", "output before seventh pixel", 32'(sent), 32'd7);
        check(out_row == ROW_W'(got), "R5", "row tag", 32'(out_row), 32'(got));
        check(out_pix == ref_out(got), req, "filtered pixel", out_pix, ref_out(got));
        got++;
      end
      prev_stall = out_valid && !out_ready;
      prev_pix   = out_pix;
      if (in_valid && in_ready) sent++;
      cyc++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    check(got == h - 6, "R5", "outputs per column", 32'(got), 32'(h - 6));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5", "no extra output", 32'(out_valid), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R8", "out_valid in reset", 32'(out_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R8", "out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", 32'(in_ready), 32'd1);

    // Default unity-gain kernel, full-height random column.
    start_col();
    fill_rand(58);
    run_col(58, 30, 20, "R2");

    // Centre-only kernel: output equals pixel three rows down, lane by lane.
    tap_edge = 0; tap_near = 0; tap_mid = 0; tap_center = 16'd256;
    start_col();
    fill_rand(20);
    run_col(20, 10, 10, "R1");

    // Rounding: a single unit weight leaves only the bias decision.
    tap_center = 16'd1;
    start_col();
    fill_rand(16);
    run_col(16, 10, 10, "R3");

    // Saturated and empty pixels under the default kernel.
    tap_edge = 16'd4; tap_near = 16'd24; tap_mid = 16'd60; tap_center = 16'd80;
    start_col();
    fill_const(10, 32'hFFFF_FFFF);
    run_col(10, 0, 0, "R3");
    start_col();
    fill_const(9, 32'h0000_0000);
    run_col(9, 0, 0, "R3");

    // Oversized weights force 16-bit wrap.
    tap_edge = 16'd300; tap_near = 16'd500; tap_mid = 16'd700; tap_center = 16'd900;
    start_col();
    fill_rand(15);
    run_col(15, 20, 20, "R4");

    // Shortest useful column.
    tap_edge = 16'd4; tap_near = 16'd24; tap_mid = 16'd60; tap_center = 16'd80;
    start_col();
    fill_rand(7);
    run_col(7, 0, 0, "R5");

    // Junk partial column, then restart: stale sums must be gone.
    start_col();
    feed_junk(5, 1'b1);
    start_col();
    fill_rand(12);
    run_col(12, 0, 0, "R6");

    // Pending output stalled, then restart drops it.
    start_col();
    feed_junk(8, 1'b0);
    #1;
    check(out_valid == 1'b1, "R7", "stalled output present", 32'(out_valid), 32'd1);
    check(in_ready == 1'b0, "R7", "input blocked under stall", 32'(in_ready), 32'd0);
    start_col();
    fill_rand(11);
    run_col(11, 0, 0, "R6");

    // Heavy output back-pressure.
    start_col();
    fill_rand(30);
    run_col(30, 70, 10, "R7");

    summary();
  end

endmodule